// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This block is a combinational 32-bit saturating datapath. It has one registered sticky flag that records whether any operation has saturated. From one operation code it performs one of these: signed or unsigned saturating add and subtract, a signed saturating doubling, or a clamp of a signed value to a chosen bit width. The width clamp works either on the full word or on two independent 16-bit lanes. A plain wrapping add is also available. It returns the modular sum and reports signed overflow only through the flag.

The result follows the operands and the operation code within the same cycle. The flag is updated at the clock edge, and only when the valid strobe is high. Once set, the flag stays set until reset or a clear strobe. Software-visible saturation tracking in a DSP pipeline can be built from this: run many operations, then inspect the flag once.

Top module: `satu_top`

## Requirements
- R1: Operation code 0 is a signed saturating add. Signed overflow occurs when A and B have the same sign and the sum's sign differs from A. On overflow the result is 0x7FFFFFFF when A is non-negative and 0x80000000 when A is negative. Overflow is a saturation event.
- R2: Operation code 1 is a signed saturating subtract A−B. Overflow occurs when A and B differ in sign and the difference's sign differs from A. The clamp value is chosen from A's sign, as in R1.
- R3: Operation code 2 is an unsigned saturating add. If the sum does not fit in 32 bits, the result is 0xFFFFFFFF and a saturation event occurs.
- R4: Operation code 3 is an unsigned saturating subtract. If B is greater than A, the result is zero and a saturation event occurs.
- R5: Operation code 4 doubles signed A. If A ≥ 0x40000000, the result is 0x7FFFFFFF. If A ≤ 0xC0000000 (signed), including exactly 0xC0000000, the result is 0x80000000. Both cases are saturation events. Otherwise the result is A shifted left by one.
- R6: Operation code 5 clamps signed A to the range −2^w … 2^w−1, where w is the 5-bit width input (0–31, a total width of w+1 bits). Values outside the range are clamped to the nearer bound and raise a saturation event. Values inside pass through unchanged.
- R7: Operation code 6 clamps signed A to 0 … 2^w−1. Negative inputs give zero, and inputs above the bound give 2^w−1. Either case is a saturation event.
- R8: Operation codes 7 (signed, rule of R6) and 8 (unsigned, rule of R7) treat A[15:0] and A[31:16] as separate sign-extended 16-bit values. Each lane is clamped independently and truncated to 16 bits. The low lane goes to result bits 15:0 and the high lane to bits 31:16. A saturation in either lane is an event.
- R9: Operation code 9 returns the modular sum A+B. When the signed add overflows (rule of R1), it raises a saturation event.
- R10: At a clock edge where valid is high and the current operation has a saturation event, the flag becomes 1. With valid low the flag is not set, whatever the operands are.
- R11: Reset clears the flag. A clear strobe clears it at the next edge, but a simultaneous valid saturation event takes priority and leaves it set. Without reset or clear, the flag never falls.
- R12: Operation codes 10 to 15 give a zero result and never raise a saturation event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation is valid; allows the flag to be set |
| clr_i | input | 1 | Clear strobe for the sticky flag |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| width_i | input | 5 | Saturation width w for codes 5–8 |
| res_o | output | 32 | Combinational result |
| flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions assume the operation code, operands, width and strobes are stable around the sampling edge. Range properties are only checked when valid is high, so the stimulus keeps valid asserted for most operations. The bench drives every input at the falling edge, so the checked values are settled at the rising edge. Flag properties assume the clear strobe is a level sampled at the edge. The stimulus therefore combines clear with and without a same-cycle saturation event, and also holds valid low while operands would saturate.

// File: rtl/satu_pkg.sv
package satu_pkg;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_SADD  = 4'd0,
    OP_SSUB  = 4'd1,
    OP_UADD  = 4'd2,
    OP_USUB  = 4'd3,
    OP_SDBL  = 4'd4,
    OP_SCLP  = 4'd5,
    OP_UCLP  = 4'd6,
    OP_SCLP2 = 4'd7,
    OP_UCLP2 = 4'd8,
    OP_WADD  = 4'd9
  } satu_op_e;
endpackage

// File: rtl/satu_arith.sv
module satu_arith #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sadd_res,
  output logic          sadd_ovf,
  output logic [DW-1:0] ssub_res,
  output logic          ssub_ovf,
  output logic [DW-1:0] uadd_res,
  output logic          uadd_ovf,
  output logic [DW-1:0] usub_res,
  output logic          usub_ovf,
  output logic [DW-1:0] sdbl_res,
  output logic          sdbl_ovf,
  output logic [DW-1:0] wadd_res
);
  localparam logic [DW-1:0] SMAX  = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] QPOS  = {2'b01, {(DW-2){1'b0}}};
  localparam logic [DW-1:0] QNEG  = {2'b11, {(DW-2){1'b0}}};

  logic [DW-1:0] sum, diff, clamp_a;
  logic          carry;
  logic          dbl_hi, dbl_lo;

  always_comb begin
    {carry, sum} = {1'b0, a} + {1'b0, b};
    diff         = a - b;
    clamp_a      = a[DW-1] ? SMIN : SMAX;

    sadd_ovf = (sum[DW-1] ^ a[DW-1]) & ~(a[DW-1] ^ b[DW-1]);
    sadd_res = sadd_ovf ? clamp_a : sum;

    ssub_ovf = (diff[DW-1] ^ a[DW-1]) & (a[DW-1] ^ b[DW-1]);
    ssub_res = ssub_ovf ? clamp_a : diff;

    uadd_ovf = carry;
    uadd_res = carry ? '1 : sum;

    usub_ovf = (diff > a);
    usub_res = usub_ovf ? '0 : diff;

    dbl_hi   = ($signed(a) >= $signed(QPOS));
    dbl_lo   = ($signed(a) <= $signed(QNEG));
    sdbl_ovf = dbl_hi | dbl_lo;
    sdbl_res = dbl_hi ? SMAX : (dbl_lo ? SMIN : {a[DW-2:0], 1'b0});

    wadd_res = sum;
  end
endmodule

// File: rtl/satu_clamp.sv
module satu_clamp #(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic [DW-1:0] val,
  input  logic [SW-1:0] sh,
  output logic [DW-1:0] sres,
  output logic          sovf,
  output logic [DW-1:0] ures,
  output logic          uovf
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] top, mask;
  logic          s_hi, s_lo, u_neg, u_big;

  always_comb begin
    top   = DW'($signed(val) >>> sh);
    mask  = (ONE << sh) - ONE;
    s_hi  = ~top[DW-1] & (top != '0);
    s_lo  = top[DW-1] & (top != '1);
    sovf  = s_hi | s_lo;
    sres  = s_hi ? mask : (s_lo ? ~mask : val);
    u_neg = val[DW-1];
    u_big = ~val[DW-1] & (val > mask);
    uovf  = u_neg | u_big;
    ures  = u_neg ? '0 : (u_big ? mask : val);
  end
endmodule

// File: rtl/satu_lanes.sv
module satu_lanes #(
  parameter int unsigned DW = 32,
  parameter int unsigned NL = 1,
  localparam int unsigned SW = $clog2(DW),
  localparam int unsigned LW = DW / NL
) (
  input  logic [DW-1:0] val,
  input  logic [SW-1:0] sh,
  output logic [DW-1:0] sres,
  output logic          sovf,
  output logic [DW-1:0] ures,
  output logic          uovf
);
  logic [NL-1:0] lane_sovf, lane_uovf;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] seg;
    logic [DW-1:0] ext, s_full, u_full;
    logic          s_o, u_o;

    assign seg = val[g*LW +: LW];
    assign ext = DW'($signed(seg));

    satu_clamp #(.DW(DW)) i_clamp (
      .val  (ext),
      .sh   (sh),
      .sres (s_full),
      .sovf (s_o),
      .ures (u_full),
      .uovf (u_o)
    );

    assign sres[g*LW +: LW] = s_full[LW-1:0];
    assign ures[g*LW +: LW] = u_full[LW-1:0];
    assign lane_sovf[g]     = s_o;
    assign lane_uovf[g]     = u_o;
  end

  assign sovf = |lane_sovf;
  assign uovf = |lane_uovf;
endmodule

// File: rtl/satu_top.sv
module satu_top
  import satu_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          clr_i,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [SW-1:0] width_i,
  output logic [DW-1:0] res_o,
  output logic          flag_o
);
  logic [DW-1:0] sadd_r, ssub_r, uadd_r, usub_r, sdbl_r, wadd_r;
  logic          sadd_v, ssub_v, uadd_v, usub_v, sdbl_v;
  logic [DW-1:0] w_sr, w_ur, h_sr, h_ur;
  logic          w_sv, w_uv, h_sv, h_uv;
  logic [DW-1:0] res_d;
  logic          evt;
  logic          flag_q, flag_d;
  satu_op_e      op;

  assign op = satu_op_e'(op_i);

  satu_arith #(.DW(DW)) i_arith (
    .a(a_i), .b(b_i),
    .sadd_res(sadd_r), .sadd_ovf(sadd_v),
    .ssub_res(ssub_r), .ssub_ovf(ssub_v),
    .uadd_res(uadd_r), .uadd_ovf(uadd_v),
    .usub_res(usub_r), .usub_ovf(usub_v),
    .sdbl_res(sdbl_r), .sdbl_ovf(sdbl_v),
    .wadd_res(wadd_r)
  );

  satu_lanes #(.DW(DW), .NL(1)) i_word (
    .val(a_i), .sh(width_i),
    .sres(w_sr), .sovf(w_sv), .ures(w_ur), .uovf(w_uv)
  );

  satu_lanes #(.DW(DW), .NL(2)) i_half (
    .val(a_i), .sh(width_i),
    .sres(h_sr), .sovf(h_sv), .ures(h_ur), .uovf(h_uv)
  );

  always_comb begin
    res_d = '0;
    evt   = 1'b0;
    unique case (op)
      OP_SADD:  begin res_d = sadd_r; evt = sadd_v; end
      OP_SSUB:  begin res_d = ssub_r; evt = ssub_v; end
      OP_UADD:  begin res_d = uadd_r; evt = uadd_v; end
      OP_USUB:  begin res_d = usub_r; evt = usub_v; end
      OP_SDBL:  begin res_d = sdbl_r; evt = sdbl_v; end
      OP_SCLP:  begin res_d = w_sr;   evt = w_sv;   end
      OP_UCLP:  begin res_d = w_ur;   evt = w_uv;   end
      OP_SCLP2: begin res_d = h_sr;   evt = h_sv;   end
      OP_UCLP2: begin res_d = h_ur;   evt = h_uv;   end
      OP_WADD:  begin res_d = wadd_r; evt = sadd_v; end
      default:  begin res_d = '0;     evt = 1'b0;   end
    endcase
  end

  // Flag next state: a valid event wins over clear.
  always_comb begin
    flag_d = flag_q;
    if (valid_i && evt) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign res_o  = res_d;
  assign flag_o = flag_q;

  AST_UADD_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd2) |-> (res_o >= a_i)); // R3
  AST_USUB_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd3) |-> (res_o <= a_i)); // R4
  AST_SCLP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd5) |->
      ((($signed(res_o) >>> width_i) == 0) || (($signed(res_o) >>> width_i) == -1))); // R6
  AST_UCLP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd6) |-> ((res_o >> width_i) == '0)); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd9) |-> (res_o == '0)); // R12
  AST_SET_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && evt) |=> flag_o); // R10
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o); // R11
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(valid_i && evt)) |=> !flag_o); // R11
endmodule

// File: tb/test_satu_top.sv
module test_satu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid, clr;
  logic [3:0]  op;
  logic [31:0] a, b;
  logic [4:0]  w;
  logic [31:0] res;
  logic        flag;

  int checks = 0;
  int errors = 0;
  bit model_flag = 1'b0;

  always #5 clk = ~clk;

  satu_top i_satu_top (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clr_i(clr),
    .op_i(op), .a_i(a), .b_i(b), .width_i(w),
    .res_o(res), .flag_o(flag)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4: return "R5";  4'd5: return "R6";
      4'd6: return "R7";  4'd7, 4'd8: return "R8";
      4'd9: return "R9";  default: return "R12";
    endcase
  endfunction

  // Clamp a signed value per R6 (sgn) or R7 (!sgn) with width k.
  task automatic clampv(input longint v, input int k, input bit sgn,
                        output longint r, output bit s);
    longint lim = longint'(1) << k;
    r = v; s = 1'b0;
    if (sgn) begin
      if (v > lim - 1) begin r = lim - 1; s = 1'b1; end
      else if (v < -lim) begin r = -lim; s = 1'b1; end
    end else begin
      if (v < 0) begin r = 0; s = 1'b1; end
      else if (v > lim - 1) begin r = lim - 1; s = 1'b1; end
    end
  endtask

  task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input int k, output logic [31:0] r, output bit s);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'(x);
    longint uy = longint'(y);
    longint t, rl, rh;
    bit sl, sh;
    r = '0; s = 1'b0;
    case (o)
      4'd0, 4'd1, 4'd9: begin
        t = (o == 4'd1) ? sx - sy : sx + sy;
        r = t[31:0];
        if (t > 64'sd2147483647) begin s = 1'b1; if (o != 4'd9) r = 32'h7FFFFFFF; end
        else if (t < -64'sd2147483648) begin s = 1'b1; if (o != 4'd9) r = 32'h80000000; end
      end
      4'd2: begin t = ux + uy; if (t > 64'hFFFFFFFF) begin r = '1; s = 1'b1; end else r = t[31:0]; end
      4'd3: begin if (ux < uy) begin r = '0; s = 1'b1; end else r = x - y; end
      4'd4: begin
        if (sx >= 64'sd1073741824) begin r = 32'h7FFFFFFF; s = 1'b1; end
        else if (sx <= -64'sd1073741824) begin r = 32'h80000000; s = 1'b1; end
        else begin t = sx * 2; r = t[31:0]; end
      end
      4'd5, 4'd6: begin clampv(sx, k, (o == 4'd5), rl, s); r = rl[31:0]; end
      4'd7, 4'd8: begin
        clampv(longint'($signed(x[15:0])), k, (o == 4'd7), rl, sl);
        clampv(longint'($signed(x[31:16])), k, (o == 4'd7), rh, sh);
        r = {rh[15:0], rl[15:0]};
        s = sl | sh;
      end
      default: begin r = '0; s = 1'b0; end
    endcase
  endtask

  task automatic run(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [4:0] k, input bit v, input bit c);
    logic [31:0] er;
    bit es;
    @(negedge clk);
    op = o; a = x; b = y; w = k; valid = v; clr = c;
    #1;
    model(o, x, y, int'(k), er, es);
    checks++;
    if (res !== er) begin
      errors++;
      $display("FAIL %s result op=%0d a=%h b=%h w=%0d: actual %h expected %h",
               req_of(o), o, x, y, k, res, er);
    end
    if (v && es) model_flag = 1'b1;
    else if (c) model_flag = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (flag !== model_flag) begin
      errors++;
      $display("FAIL %s flag op=%0d valid=%0b clr=%0b: actual %b expected %b",
               c ? "R11" : (v ? "R10" : "R10 (valid low)"), o, v, c, flag, model_flag);
    end
  endtask

  task automatic clear_flag;
    run(4'd15, 32'h0, 32'h0, 5'd0, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; clr = 1'b0; op = '0; a = '0; b = '0; w = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (flag !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset flag: actual %b expected 0", flag);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1 signed add
    run(4'd0, 32'd5, 32'd7, 5'd0, 1, 0);
    run(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 1, 0);
    clear_flag();
    run(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1, 0);
    clear_flag();
    // R2 signed subtract
    run(4'd1, 32'h80000000, 32'd1, 5'd0, 1, 0);
    run(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1, 0);
    clear_flag();
    run(4'd1, 32'd3, 32'd10, 5'd0, 1, 0);
    // R3, R4 unsigned
    run(4'd2, 32'hFFFFFFFF, 32'd1, 5'd0, 1, 0);
    clear_flag();
    run(4'd3, 32'd0, 32'd1, 5'd0, 1, 0);
    clear_flag();
    run(4'd3, 32'd9, 32'd9, 5'd0, 1, 0);
    // R5 doubling boundaries
    run(4'd4, 32'h3FFFFFFF, 32'd0, 5'd0, 1, 0);
    run(4'd4, 32'h40000000, 32'd0, 5'd0, 1, 0);
    clear_flag();
    run(4'd4, 32'hC0000001, 32'd0, 5'd0, 1, 0);
    run(4'd4, 32'hC0000000, 32'd0, 5'd0, 1, 0);
    clear_flag();
    // R6 signed width clamp
    run(4'd5, 32'd200, 32'd0, 5'd7, 1, 0);
    clear_flag();
    run(4'd5, -32'sd300, 32'd0, 5'd7, 1, 0);
    clear_flag();
    run(4'd5, 32'd1, 32'd0, 5'd0, 1, 0);
    clear_flag();
    run(4'd5, 32'h80000000, 32'd0, 5'd31, 1, 0);
    // R7 unsigned width clamp
    run(4'd6, 32'd5, 32'd0, 5'd0, 1, 0);
    clear_flag();
    run(4'd6, 32'h80000000, 32'd0, 5'd31, 1, 0);
    clear_flag();
    run(4'd6, 32'h7FFFFFFF, 32'd0, 5'd31, 1, 0);
    // R8 lanes
    run(4'd7, 32'h80007FFF, 32'd0, 5'd7, 1, 0);
    clear_flag();
    run(4'd7, 32'h00400010, 32'd0, 5'd7, 1, 0);
    run(4'd8, 32'h80000123, 32'd0, 5'd15, 1, 0);
    clear_flag();
    run(4'd8, 32'h00050300, 32'd0, 5'd8, 1, 0);
    clear_flag();
    // R9 wrapping add
    run(4'd9, 32'h7FFFFFFF, 32'd1, 5'd0, 1, 0);
    clear_flag();
    run(4'd9, 32'hFFFFFFFF, 32'd1, 5'd0, 1, 0);
    // R10 valid low does not set
    run(4'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 5'd0, 0, 0);
    // R11 set wins over clear, then hold, then clear
    run(4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1, 1);
    run(4'd0, 32'd1, 32'd1, 5'd0, 1, 0);
    run(4'd0, 32'd1, 32'd1, 5'd0, 1, 1);
    // R12 reserved codes
    for (int o = 10; o < 16; o++) run(4'(o), 32'hFFFFFFFF, 32'h80000000, 5'd3, 1, 0);

    // Mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (($urandom % 4) == 0) ra = {ra[31], {3{ra[30]}}, ra[27:0]};
      run(4'($urandom % 16), ra, rb, 5'($urandom), (($urandom % 8) != 0),
          (($urandom % 6) == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule